// File: doc/BRIEF.md
# Fixed-Frame SPI Command Slave

This block is the serial front-end of a peripheral that talks to a host controller over an SPI link in clock mode 0. Every chip-select cycle carries one full-duplex exchange of exactly sixteen bits. The host shifts in a command word whose two leading bits pick one of four operations: write configuration, read configuration, write data or read data. At the same time the block shifts out a sixteen-bit response word that it took from the back-end when chip select fell.

The SPI pins are brought into the system clock domain through synchronizer chains. All decisions are made on edges detected in that domain. A command reaches the back-end only once chip select rises, and only if exactly sixteen SCLK rising edges were seen. It arrives as a one-cycle strobe together with the opcode, the fourteen payload bits and a test-mode flag. Any frame with a different length is discarded.

Top module: `spi_cmd_slave`

## Requirements
- R1: MOSI is sampled on each SCLK rising edge while chip select is low, most significant bit first. After a full frame, `cmd_payload` equals input bits 13:0.
- R2: Response bit 15 appears on MISO after chip select falls and before the first SCLK edge. Each later bit, from 14 down to 0, appears after the SCLK falling edge that follows the previous bit's rising edge.
- R3: The response word is captured from `rsp_word` at the chip-select falling edge. Changing `rsp_word` during the frame has no effect on the bits shifted out.
- R4: A frame with exactly sixteen SCLK rising edges produces exactly one `cmd_valid` pulse, one system clock wide, a few cycles after chip select rises and never before it.
- R5: A frame with fewer than sixteen SCLK rising edges produces no `cmd_valid` pulse.
- R6: A frame with more than sixteen SCLK rising edges produces no `cmd_valid` pulse.
- R7: `cmd_op` carries input bits 15:14 with the encoding 2'b11 = write configuration, 2'b01 = read configuration, 2'b10 = write data, 2'b00 = read data.
- R8: In a write-configuration frame (input bits 15:14 = 2'b11), MISO shows captured response bits 15 and 14, then fourteen zeros, whatever `rsp_word` held.
- R9: `cmd_test` is high with the strobe only for a read-configuration frame whose input bit 0 is 1. Otherwise it is low.
- R10: Every chip-select falling edge restarts the bit count, so a full frame that follows an aborted one is accepted normally.
- R11: MISO is low while chip select is high. After reset, `cmd_valid`, `cmd_test` and MISO are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial response to the host |
| rsp_word | input | 16 | Response word offered by the back-end |
| cmd_valid | output | 1 | One-cycle strobe for a committed frame |
| cmd_op | output | 2 | Opcode of the committed frame |
| cmd_payload | output | 14 | Input bits 13:0 of the committed frame |
| cmd_test | output | 1 | Test-mode request (read configuration with bit 0 set) |

## Verification
The hardest conditions to reach are the frame-length corner cases: chip select rising after fifteen or fewer edges, or after seventeen or more. They matter most when followed at once by a clean frame, because that is the only way to show the counter restarted. The bench drives the frame task with an explicit edge count and chains short, long and normal frames back to back. It also flips `rsp_word` in the middle of every frame, so a design that samples the response late is caught by a wrong MISO bit.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int FRAME_W = 16;
  localparam int OP_W    = 2;

  typedef enum logic [OP_W-1:0] {
    OP_RDATA = 2'b00,
    OP_RCFG  = 2'b01,
    OP_WDATA = 2'b10,
    OP_WCFG  = 2'b11
  } op_e;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int         N       = 3,
  parameter int         STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] d_out
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      logic [STAGES-1:0] pipe_q;
      logic [STAGES-1:0] pipe_d;
      always_comb pipe_d = {pipe_q[STAGES-2:0], d_in[g]};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL[g]}};
        else        pipe_q <= pipe_d;
      end
      assign d_out[g] = pipe_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_act,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sclk_rise,
  input  logic             mosi,
  output logic             op_known,
  output op_e              op_cur,
  output logic             cmd_valid,
  output op_e              cmd_op,
  output logic [FW-OP_W-1:0] cmd_payload,
  output logic             cmd_test
);
  localparam int PW      = FW - OP_W;
  localparam int CNT_MAX = FW + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic [FW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          known_q, known_d;
  op_e           opc_q, opc_d;
  logic          vld_q, vld_d;
  op_e           op_q, op_d;
  logic [PW-1:0] pay_q, pay_d;
  logic          tst_q, tst_d;
  logic          full;

  assign full = (cnt_q == CW'(FW));

  always_comb begin
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    known_d = known_q;
    opc_d   = opc_q;
    vld_d   = 1'b0;
    op_d    = op_q;
    pay_d   = pay_q;
    tst_d   = 1'b0;
    if (cs_fall) begin
      sh_d    = '0;
      cnt_d   = '0;
      known_d = 1'b0;
    end else if (cs_act && sclk_rise) begin
      sh_d = {sh_q[FW-2:0], mosi};
      if (cnt_q != CW'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(1)) begin
        known_d = 1'b1;
        opc_d   = op_e'({sh_q[0], mosi});
      end
    end
    if (cs_rise && full) begin
      vld_d = 1'b1;
      op_d  = op_e'(sh_q[FW-1 -: OP_W]);
      pay_d = sh_q[PW-1:0];
      tst_d = (op_e'(sh_q[FW-1 -: OP_W]) == OP_RCFG) && sh_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      known_q <= 1'b0;
      opc_q   <= OP_RDATA;
      vld_q   <= 1'b0;
      op_q    <= OP_RDATA;
      pay_q   <= '0;
      tst_q   <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      known_q <= known_d;
      opc_q   <= opc_d;
      vld_q   <= vld_d;
      op_q    <= op_d;
      pay_q   <= pay_d;
      tst_q   <= tst_d;
    end
  end

  assign op_known    = known_q;
  assign op_cur      = opc_q;
  assign cmd_valid   = vld_q;
  assign cmd_op      = op_q;
  assign cmd_payload = pay_q;
  assign cmd_test    = tst_q;

  // R4: strobe is one cycle wide
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  // R4: strobe only follows a chip-select rise
  p_after_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(cs_rise));
  // R5/R6: a wrong-length frame yields no strobe
  p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && (cnt_q != CW'(FW))) |=> !cmd_valid);
  // R9: test flag only with a read-configuration strobe
  p_test_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_test |-> (cmd_valid && cmd_op == OP_RCFG));
endmodule

// File: rtl/spi_cmd_tx.sv
module spi_cmd_tx
  import spi_cmd_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          cs_fall,
  input  logic          sclk_fall,
  input  logic          op_known,
  input  op_e           op_cur,
  input  logic [FW-1:0] rsp_word,
  output logic          miso
);
  logic [FW-1:0] sh_q, sh_d;
  logic          tail_zero;

  assign tail_zero = op_known && (op_cur == OP_WCFG);

  always_comb begin
    sh_d = sh_q;
    if (cs_fall)
      sh_d = rsp_word;
    else if (cs_act && sclk_fall)
      sh_d = tail_zero ? '0 : {sh_q[FW-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign miso = cs_act & sh_q[FW-1];

  // R3: response captured at chip-select fall
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sh_q == $past(rsp_word)));
  // R8: write-configuration tail is all zeros
  p_wcfg_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && sclk_fall && tail_zero) |=> !miso);
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spi_sclk,
  input  logic                    spi_csn,
  input  logic                    spi_mosi,
  output logic                    spi_miso,
  input  logic [FRAME_W-1:0]      rsp_word,
  output logic                    cmd_valid,
  output logic [OP_W-1:0]         cmd_op,
  output logic [FRAME_W-OP_W-1:0] cmd_payload,
  output logic                    cmd_test
);
  logic [2:0] raw, synced;
  logic       sclk_s, csn_s, mosi_s;
  logic       sclk_p, csn_p;
  logic       cs_act, cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic       op_known;
  op_e        op_cur, op_out;

  assign raw = {spi_csn, spi_sclk, spi_mosi};

  spi_cmd_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(raw), .d_out(synced)
  );
  assign {csn_s, sclk_s, mosi_s} = synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= 1'b0;
      csn_p  <= 1'b1;
    end else begin
      sclk_p <= sclk_s;
      csn_p  <= csn_s;
    end
  end

  assign cs_act    = ~csn_s;
  assign cs_fall   = csn_p & ~csn_s;
  assign cs_rise   = ~csn_p & csn_s;
  assign sclk_rise = ~sclk_p & sclk_s;
  assign sclk_fall = sclk_p & ~sclk_s;

  spi_cmd_rx #(.FW(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sclk_rise(sclk_rise), .mosi(mosi_s),
    .op_known(op_known), .op_cur(op_cur), .cmd_valid(cmd_valid),
    .cmd_op(op_out), .cmd_payload(cmd_payload), .cmd_test(cmd_test)
  );

  spi_cmd_tx #(.FW(FRAME_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall),
    .sclk_fall(sclk_fall), .op_known(op_known), .op_cur(op_cur),
    .rsp_word(rsp_word), .miso(spi_miso)
  );

  assign cmd_op = op_out;

  // R11: no MISO activity once chip select has settled high
  p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && csn_p) |-> !spi_miso);
endmodule

// File: tb/sim_spi_cmd_slave.sv
module sim_spi_cmd_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic        miso;
  logic [15:0] rsp = 16'h0;
  logic        vld, tst;
  logic [1:0]  op;
  logic [13:0] pay;

  int checks = 0, errors = 0;
  int pulses = 0;
  logic [1:0]  cap_op;
  logic [13:0] cap_pay;
  logic        cap_tst;
  logic        prev_vld = 1'b0;
  int          idle_cnt = 0;

  always #5 clk = ~clk;

  spi_cmd_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn),
    .spi_mosi(mosi), .spi_miso(miso), .rsp_word(rsp), .cmd_valid(vld),
    .cmd_op(op), .cmd_payload(pay), .cmd_test(tst)
  );

  // per-clock reference observation
  always @(negedge clk) begin
    if (rst_n) begin
      if (vld) begin
        pulses++;
        cap_op = op; cap_pay = pay; cap_tst = tst;
      end
      if (vld && prev_vld) begin
        checks++; errors++;
        $display("FAIL R4 strobe wider than one cycle act=1 exp=0");
      end
      idle_cnt = csn ? idle_cnt + 1 : 0;
      if (idle_cnt > 6) begin
        checks++;
        if (miso !== 1'b0) begin
          errors++;
          $display("FAIL R11 miso while deselected act=%b exp=0", miso);
        end
      end
      prev_vld = vld;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] din, input int nbits,
                       input logic [15:0] r, output logic [15:0] dout,
                       output int np);
    int p0;
    dout = '0;
    p0 = pulses;
    rsp = r;
    repeat (4) @(posedge clk);
    csn = 1'b0;
    repeat (8) @(posedge clk);
    rsp = ~r;
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? din[15-i] : 1'b0;
      repeat (4) @(posedge clk);
      #1;
      if (i < 16) dout[15-i] = miso;
      sclk = 1'b1;
      repeat (8) @(posedge clk);
      sclk = 1'b0;
      repeat (4) @(posedge clk);
    end
    repeat (4) @(posedge clk);
    csn = 1'b1;
    repeat (12) @(posedge clk);
    np = pulses - p0;
  endtask

  task automatic good(input string req, input logic [15:0] din,
                      input logic [15:0] r, input logic exp_tst);
    logic [15:0] d, exp_d;
    int np;
    frame(din, 16, r, d, np);
    exp_d = (din[15:14] == 2'b11) ? {r[15:14], 14'h0} : r;
    chk({req, " R4 one strobe"}, np, 1);
    chk({req, " R7 opcode"}, cap_op, din[15:14]);
    chk({req, " R1 payload"}, cap_pay, din[13:0]);
    chk({req, " R9 test flag"}, cap_tst, exp_tst);
    chk({req, " R2 R3 response"}, d, exp_d);
  endtask

  initial begin
    logic [15:0] d;
    int np;
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    repeat (5) @(posedge clk);
    #1;
    chk("R11 reset valid", vld, 0);
    chk("R11 reset test", tst, 0);
    chk("R11 reset miso", miso, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    good("R7 wdata", 16'hA5C3, 16'h8123, 1'b0);
    good("R7 rdata", 16'h0000, 16'h5A96, 1'b0);
    good("R9 rcfg test", 16'h4001, 16'hC3F0, 1'b1);
    good("R9 rcfg plain", 16'h7FFE, 16'h1234, 1'b0);
    good("R8 wcfg", 16'hFFFF, 16'hFFFF, 1'b0);
    good("R8 wcfg low", 16'hC0AA, 16'h7FFF, 1'b0);

    frame(16'hA123, 10, 16'h0F0F, d, np);
    chk("R5 short frame", np, 0);
    frame(16'hB456, 15, 16'h0F0F, d, np);
    chk("R5 fifteen bits", np, 0);
    good("R10 after short", 16'h9ABC, 16'h6B2D, 1'b0);
    frame(16'h8001, 18, 16'h0F0F, d, np);
    chk("R6 long frame", np, 0);
    frame(16'hC000, 17, 16'h0F0F, d, np);
    chk("R6 seventeen bits", np, 0);
    good("R10 after long", 16'h3FFF, 16'hE001, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule